// File: doc/BRIEF.md
# Byte-to-Word ATA PIO Bridge

This block connects an 8-bit processor register bus to a 16-bit ATA-style disk interface that runs in programmed I/O mode. A 32-byte address window is split into two halves, and each half drives one of the disk's two chip selects. Any processor read inside the window runs one disk read cycle, and any write runs one disk write cycle. The disk register number comes from the byte offset shifted right by one. The parity of the address picks which byte lane the processor byte uses. The other lane comes from, or goes to, a pair of 16-bit holding buffers. One buffer holds read data and the other holds write data. Both belong to the bridge alone, so a full word can be moved one byte at a time and stays consistent.

Two more byte addresses reach the holding buffers directly and cause no disk activity. A control byte drives the disk reset line, and that line is held in reset until software releases it. Each disk cycle has three phases: setup, strobe-active and recovery. The length of each phase is set in clock cycles on its own input. The processor is stalled from the cycle after it issues a disk access until recovery ends. Requests made while the stall is high are ignored.

Top module: `ata_pio_bridge`

## Requirements
- R1: A read in 0xFF60..0xFF7F pulls `dsk_rd_n` low, and a write in that range pulls `dsk_wr_n` low. The strobe is low for exactly the strobe-active count of cycles. The two strobes are never low together, and neither is low unless a chip select is low.
- R2: Offsets 0x00..0x0F of the window drive `dsk_cs_n = 2'b10`, and offsets 0x10..0x1F drive `dsk_cs_n = 2'b01` (both active low). `dsk_addr` equals offset bits [3:1] and is stable for the whole cycle. When the bridge is idle, `dsk_cs_n = 2'b11`.
- R3: On an even-address disk write, `dsk_dout = {write-buffer high byte, processor byte}`. On an odd-address disk write, `dsk_dout = {processor byte, write-buffer low byte}`.
- R4: A disk read stores all 16 bits of `dsk_din`, sampled at the end of the last strobe-active cycle, into the read buffer. `cpu_rdata` then returns bits [7:0] for an even address and bits [15:8] for an odd address.
- R5: Address 0xFF42 reads the read-buffer low byte and writes the write-buffer low byte. Address 0xFF43 does the same with the high bytes. These accesses cause no strobe and no stall, and read data appears in the cycle after the request.
- R6: The read and write buffers are separate. Writing 0xFF42 and then reading 0xFF42 returns the read-buffer byte, not the byte just written.
- R7: `dsk_reset_n` is 0 after reset. A write to 0xFF40 sets it to bit 0 of the write data. A read of 0xFF40 returns `{7'b0, bit}`.
- R8: The setup, strobe-active and recovery phases last `t_setup`, `t_active` and `t_recov` cycles, and a count of 0 acts as 1. `cpu_stall` is high for the sum of the three phases, starting in the cycle after acceptance. A request made while `cpu_stall` is high is ignored.
- R9: `dsk_oe` is high only during write cycles, through all of setup, strobe-active and recovery.
- R10: Accesses to any other address change neither buffer nor the reset bit and cause no disk cycle. Reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, taken when `cpu_stall` is low |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte, valid once the stall is low |
| cpu_stall | output | 1 | High while a disk cycle is in progress |
| t_setup | input | 4 | Setup phase length in cycles |
| t_active | input | 4 | Strobe-active phase length in cycles |
| t_recov | input | 4 | Recovery phase length in cycles |
| dsk_cs_n | output | 2 | Disk chip selects, active low, bit 0 = lower half of window |
| dsk_addr | output | 3 | Disk register address |
| dsk_rd_n | output | 1 | Disk read strobe, active low |
| dsk_wr_n | output | 1 | Disk write strobe, active low |
| dsk_oe | output | 1 | Enable for the disk data drivers |
| dsk_dout | output | 16 | Data driven to the disk |
| dsk_din | input | 16 | Data from the disk |
| dsk_reset_n | output | 1 | Disk reset line, active low |

## Verification
A wrong phase counter shows within a single disk cycle: a strobe of the wrong length, or a stall that ends too early or too late, appears at the ports in the same cycle the counter goes wrong. A corrupted holding buffer stays hidden until the next odd or even access that uses the other lane, or the next read of 0xFF42 or 0xFF43. For that reason the bench reads back both lanes after every kind of traffic that must leave the buffers alone. A captured operation with the wrong lane or chip select is visible on `dsk_dout`, `dsk_cs_n` and `dsk_addr` from the first setup cycle onward.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV
    } ata_phase_e;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_DISK,
        AK_RESET,
        AK_BUF_LO,
        AK_BUF_HI
    } acc_kind_e;

endpackage

// File: rtl/ata_addr_decode.sv
module ata_addr_decode
    import ata_bridge_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                OFS_W       = 5,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hFF60,
    parameter logic [ADDR_W-1:0] RST_ADDR    = 16'hFF40,
    parameter logic [ADDR_W-1:0] BUF_LO_ADDR = 16'hFF42,
    parameter logic [ADDR_W-1:0] BUF_HI_ADDR = 16'hFF43
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic              region,
    output logic [OFS_W-3:0]  reg_idx,
    output logic              odd
);

    logic [OFS_W-1:0] offset;
    logic             in_win;

    assign offset  = addr[OFS_W-1:0];
    assign in_win  = (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
    assign region  = offset[OFS_W-1];
    assign reg_idx = offset[OFS_W-2:1];
    assign odd     = offset[0];

    always_comb begin
        if (in_win)                    kind = AK_DISK;
        else if (addr == RST_ADDR)     kind = AK_RESET;
        else if (addr == BUF_LO_ADDR)  kind = AK_BUF_LO;
        else if (addr == BUF_HI_ADDR)  kind = AK_BUF_HI;
        else                           kind = AK_NONE;
    end

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
    import ata_bridge_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] t_setup,
    input  logic [CNT_W-1:0] t_active,
    input  logic [CNT_W-1:0] t_recov,
    output ata_phase_e       phase,
    output logic             busy,
    output logic             sample
);

    typedef struct packed {
        ata_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } tstate_t;

    tstate_t st_d, st_q;

    // A zero count is treated as one cycle.
    function automatic logic [CNT_W-1:0] last_of(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - CNT_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_SETUP;
                    st_d.cnt   = last_of(t_setup);
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = last_of(t_active);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_RECOV;
                    st_d.cnt   = last_of(t_recov);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_RECOV: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.phase;
    assign busy   = (st_q.phase != PH_IDLE);
    assign sample = (st_q.phase == PH_ACTIVE) && (st_q.cnt == '0);

endmodule

// File: rtl/ata_data_path.sv
module ata_data_path
    import ata_bridge_pkg::*;
#(
    parameter int DSK_ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  cpu_wr,
    input  acc_kind_e             kind,
    input  logic                  region,
    input  logic [DSK_ADDR_W-1:0] reg_idx,
    input  logic                  odd,
    input  logic [7:0]            wdata,
    input  logic                  sample,
    input  logic [15:0]           din,
    output logic                  op_wr,
    output logic                  op_cs1,
    output logic [DSK_ADDR_W-1:0] op_reg,
    output logic [15:0]           dout,
    output logic [7:0]            rdata,
    output logic                  reset_n
);

    typedef struct packed {
        logic [15:0]           rbuf;
        logic [15:0]           wbuf;
        logic                  rst_bit;
        logic [7:0]            rdata;
        logic                  op_wr;
        logic                  op_cs1;
        logic [DSK_ADDR_W-1:0] op_reg;
        logic                  op_odd;
        logic [15:0]           dout;
    } dstate_t;

    dstate_t ds_d, ds_q;

    always_comb begin
        ds_d = ds_q;
        if (accept) begin
            case (kind)
                AK_DISK: begin
                    ds_d.op_wr  = cpu_wr;
                    ds_d.op_cs1 = region;
                    ds_d.op_reg = reg_idx;
                    ds_d.op_odd = odd;
                    if (cpu_wr) begin
                        ds_d.dout = odd ? {wdata, ds_q.wbuf[7:0]}
                                        : {ds_q.wbuf[15:8], wdata};
                    end
                end
                AK_RESET: begin
                    if (cpu_wr) ds_d.rst_bit = wdata[0];
                    else        ds_d.rdata   = {7'b0, ds_q.rst_bit};
                end
                AK_BUF_LO: begin
                    if (cpu_wr) ds_d.wbuf[7:0] = wdata;
                    else        ds_d.rdata     = ds_q.rbuf[7:0];
                end
                AK_BUF_HI: begin
                    if (cpu_wr) ds_d.wbuf[15:8] = wdata;
                    else        ds_d.rdata      = ds_q.rbuf[15:8];
                end
                default: begin
                    if (!cpu_wr) ds_d.rdata = 8'h00;
                end
            endcase
        end
        // Capture the disk word at the end of the strobe-active phase of a read.
        if (sample && !ds_q.op_wr) begin
            ds_d.rbuf  = din;
            ds_d.rdata = ds_q.op_odd ? din[15:8] : din[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_q <= '0;
        end else begin
            ds_q <= ds_d;
        end
    end

    assign op_wr   = ds_q.op_wr;
    assign op_cs1  = ds_q.op_cs1;
    assign op_reg  = ds_q.op_reg;
    assign dout    = ds_q.dout;
    assign rdata   = ds_q.rdata;
    assign reset_n = ds_q.rst_bit;

endmodule

// File: rtl/ata_pio_bridge.sv
module ata_pio_bridge
    import ata_bridge_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                DSK_ADDR_W  = 3,
    parameter int                CNT_W       = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hFF60,
    parameter logic [ADDR_W-1:0] RST_ADDR    = 16'hFF40,
    parameter logic [ADDR_W-1:0] BUF_LO_ADDR = 16'hFF42,
    parameter logic [ADDR_W-1:0] BUF_HI_ADDR = 16'hFF43
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_wr,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [7:0]            cpu_wdata,
    output logic [7:0]            cpu_rdata,
    output logic                  cpu_stall,
    input  logic [CNT_W-1:0]      t_setup,
    input  logic [CNT_W-1:0]      t_active,
    input  logic [CNT_W-1:0]      t_recov,
    output logic [1:0]            dsk_cs_n,
    output logic [DSK_ADDR_W-1:0] dsk_addr,
    output logic                  dsk_rd_n,
    output logic                  dsk_wr_n,
    output logic                  dsk_oe,
    output logic [15:0]           dsk_dout,
    input  logic [15:0]           dsk_din,
    output logic                  dsk_reset_n
);

    localparam int OFS_W  = DSK_ADDR_W + 2;
    localparam int NUM_CS = 2;

    acc_kind_e             kind;
    logic                  region;
    logic [DSK_ADDR_W-1:0] reg_idx;
    logic                  odd;
    logic                  busy;
    logic                  sample;
    logic                  accept;
    logic                  start;
    ata_phase_e            phase;
    logic                  op_wr;
    logic                  op_cs1;
    logic [DSK_ADDR_W-1:0] op_reg;

    assign accept = cpu_req && !busy;
    assign start  = accept && (kind == AK_DISK);

    ata_addr_decode #(
        .ADDR_W      (ADDR_W),
        .OFS_W       (OFS_W),
        .WIN_BASE    (WIN_BASE),
        .RST_ADDR    (RST_ADDR),
        .BUF_LO_ADDR (BUF_LO_ADDR),
        .BUF_HI_ADDR (BUF_HI_ADDR)
    ) u_dec (
        .addr    (cpu_addr),
        .kind    (kind),
        .region  (region),
        .reg_idx (reg_idx),
        .odd     (odd)
    );

    ata_strobe_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .t_setup  (t_setup),
        .t_active (t_active),
        .t_recov  (t_recov),
        .phase    (phase),
        .busy     (busy),
        .sample   (sample)
    );

    ata_data_path #(
        .DSK_ADDR_W (DSK_ADDR_W)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .cpu_wr  (cpu_wr),
        .kind    (kind),
        .region  (region),
        .reg_idx (reg_idx),
        .odd     (odd),
        .wdata   (cpu_wdata),
        .sample  (sample),
        .din     (dsk_din),
        .op_wr   (op_wr),
        .op_cs1  (op_cs1),
        .op_reg  (op_reg),
        .dout    (dsk_dout),
        .rdata   (cpu_rdata),
        .reset_n (dsk_reset_n)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign dsk_cs_n[g] = ~(busy && (op_cs1 == 1'(g)));
    end

    assign cpu_stall = busy;
    assign dsk_addr  = op_reg;
    assign dsk_rd_n  = ~((phase == PH_ACTIVE) && !op_wr);
    assign dsk_wr_n  = ~((phase == PH_ACTIVE) && op_wr);
    assign dsk_oe    = busy && op_wr;

endmodule

// File: rtl/ata_pio_bridge_chk.sv
module ata_pio_bridge_chk #(
    parameter int                ADDR_W      = 16,
    parameter int                DSK_ADDR_W  = 3,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hFF60,
    parameter logic [ADDR_W-1:0] RST_ADDR    = 16'hFF40,
    parameter logic [ADDR_W-1:0] BUF_LO_ADDR = 16'hFF42,
    parameter logic [ADDR_W-1:0] BUF_HI_ADDR = 16'hFF43
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_req,
    input logic                  cpu_wr,
    input logic [ADDR_W-1:0]     cpu_addr,
    input logic                  wd0,
    input logic                  cpu_stall,
    input logic [1:0]            dsk_cs_n,
    input logic [DSK_ADDR_W-1:0] dsk_addr,
    input logic                  dsk_rd_n,
    input logic                  dsk_wr_n,
    input logic                  dsk_oe,
    input logic                  dsk_reset_n
);

    localparam int OFS_W = DSK_ADDR_W + 2;

    logic acc, in_win;
    assign acc    = cpu_req && !cpu_stall;
    assign in_win = (cpu_addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);

    a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dsk_cs_n));

    a_r1_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dsk_rd_n && !dsk_wr_n));

    a_r1_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsk_rd_n || !dsk_wr_n) |-> (dsk_cs_n != 2'b11));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> (dsk_cs_n == 2'b11 && dsk_rd_n && dsk_wr_n && !dsk_oe));

    a_r9_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_oe |-> dsk_rd_n);

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_cs_n != 2'b11 && $past(dsk_cs_n) != 2'b11) |-> $stable(dsk_addr));

    a_r1_window_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_win) |=> cpu_stall);

    a_r5_buf_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (cpu_addr == BUF_LO_ADDR || cpu_addr == BUF_HI_ADDR)) |=> !cpu_stall);

    a_r7_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpu_wr && cpu_addr == RST_ADDR) |=> (dsk_reset_n == $past(wd0)));

endmodule

bind ata_pio_bridge ata_pio_bridge_chk #(
    .ADDR_W      (ADDR_W),
    .DSK_ADDR_W  (DSK_ADDR_W),
    .WIN_BASE    (WIN_BASE),
    .RST_ADDR    (RST_ADDR),
    .BUF_LO_ADDR (BUF_LO_ADDR),
    .BUF_HI_ADDR (BUF_HI_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_wr      (cpu_wr),
    .cpu_addr    (cpu_addr),
    .wd0         (cpu_wdata[0]),
    .cpu_stall   (cpu_stall),
    .dsk_cs_n    (dsk_cs_n),
    .dsk_addr    (dsk_addr),
    .dsk_rd_n    (dsk_rd_n),
    .dsk_wr_n    (dsk_wr_n),
    .dsk_oe      (dsk_oe),
    .dsk_reset_n (dsk_reset_n)
);

// File: tb/ata_pio_bridge_tb.sv
module ata_pio_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall;
    logic [3:0]  t_setup = 4'd2, t_active = 4'd3, t_recov = 4'd2;
    logic [1:0]  dsk_cs_n;
    logic [2:0]  dsk_addr;
    logic        dsk_rd_n, dsk_wr_n, dsk_oe, dsk_reset_n;
    logic [15:0] dsk_dout;
    logic [15:0] dsk_din = '0;

    always #2 clk = ~clk;

    ata_pio_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .t_setup(t_setup), .t_active(t_active),
        .t_recov(t_recov), .dsk_cs_n(dsk_cs_n), .dsk_addr(dsk_addr),
        .dsk_rd_n(dsk_rd_n), .dsk_wr_n(dsk_wr_n), .dsk_oe(dsk_oe),
        .dsk_dout(dsk_dout), .dsk_din(dsk_din), .dsk_reset_n(dsk_reset_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int eff(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction

    // Behavioural reference model
    bit          m_busy = 0, m_wr = 0, m_cs1 = 0, m_odd = 0, m_rst = 0;
    int          m_c = 0, eS = 1, eA = 1, eR = 1;
    logic [2:0]  m_reg = '0;
    logic [15:0] m_word = '0, m_rbuf = '0, m_wbuf = '0;
    logic [7:0]  m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rst = 0; m_rbuf = '0; m_wbuf = '0; m_rdata = '0;
            m_word = '0; m_c = 0;
        end else if (m_busy) begin
            if (m_c == eS + eA - 1 && !m_wr) begin
                m_rbuf  = dsk_din;
                m_rdata = m_odd ? dsk_din[15:8] : dsk_din[7:0];
            end
            if (m_c == eS + eA + eR - 1) m_busy = 0;
            else m_c++;
        end else if (cpu_req) begin
            if ((cpu_addr & 16'hFFE0) == 16'hFF60) begin
                m_busy = 1; m_c = 0;
                eS = eff(t_setup); eA = eff(t_active); eR = eff(t_recov);
                m_wr = cpu_wr; m_cs1 = cpu_addr[4]; m_reg = cpu_addr[3:1];
                m_odd = cpu_addr[0];
                if (cpu_wr)
                    m_word = m_odd ? {cpu_wdata, m_wbuf[7:0]} : {m_wbuf[15:8], cpu_wdata};
            end else if (cpu_addr == 16'hFF40) begin
                if (cpu_wr) m_rst = cpu_wdata[0]; else m_rdata = {7'b0, m_rst};
            end else if (cpu_addr == 16'hFF42) begin
                if (cpu_wr) m_wbuf[7:0] = cpu_wdata; else m_rdata = m_rbuf[7:0];
            end else if (cpu_addr == 16'hFF43) begin
                if (cpu_wr) m_wbuf[15:8] = cpu_wdata; else m_rdata = m_rbuf[15:8];
            end else if (!cpu_wr) begin
                m_rdata = 8'h00;
            end
        end
    end

    // Per-cycle comparison and activity counters
    int          n_stall = 0, n_oe = 0, n_rd = 0, n_wr = 0;
    logic [15:0] last_dout = '0;
    logic [1:0]  last_cs = 2'b11;
    logic [2:0]  last_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit act_ph;
            act_ph = m_busy && (m_c >= eS) && (m_c < eS + eA);
            chk("R8 stall", cpu_stall, m_busy);
            chk("R2 cs_n", dsk_cs_n, m_busy ? (m_cs1 ? 2'b01 : 2'b10) : 2'b11);
            if (m_busy) chk("R2 dsk_addr", dsk_addr, m_reg);
            chk("R1 rd_n", dsk_rd_n, !(act_ph && !m_wr));
            chk("R1 wr_n", dsk_wr_n, !(act_ph && m_wr));
            chk("R9 oe", dsk_oe, m_busy && m_wr);
            if (m_busy && m_wr) chk("R3 dout", dsk_dout, m_word);
            chk("R7 reset_n", dsk_reset_n, m_rst);
            chk("R4 rdata", cpu_rdata, m_rdata);
            if (cpu_stall) n_stall++;
            if (dsk_oe) begin n_oe++; last_dout = dsk_dout; end
            if (!dsk_rd_n) n_rd++;
            if (!dsk_wr_n) n_wr++;
            if (cpu_stall) begin last_cs = dsk_cs_n; last_addr = dsk_addr; end
        end
    end

    task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (cpu_stall) @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        while (cpu_stall) @(negedge clk);
    endtask

    int s_stall, s_oe, s_rd, s_wr;
    task automatic snap();
        s_stall = n_stall; s_oe = n_oe; s_rd = n_rd; s_wr = n_wr;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R8 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset state reset_n", dsk_reset_n, 0);
        chk("R8 reset state stall", cpu_stall, 0);
        chk("R2 reset state cs_n", dsk_cs_n, 2'b11);
        rst_n = 1'b1;

        // R7 release reset line and read it back
        access(1, 16'hFF40, 8'h01);
        chk("R7 reset_n after write 1", dsk_reset_n, 1);
        access(0, 16'hFF40, 8'h00);
        chk("R7 readback", cpu_rdata, 8'h01);

        // R5 load write buffer, R3 even write in lower half
        access(1, 16'hFF43, 8'hA5);
        access(1, 16'hFF42, 8'h3C);
        snap();
        access(1, 16'hFF64, 8'h11);
        chk("R3 even write word", last_dout, 16'hA511);
        chk("R2 cs lower half", last_cs, 2'b10);
        chk("R2 reg addr", last_addr, 2);
        chk("R8 stall cycles 2+3+2", n_stall - s_stall, 7);
        chk("R1 write strobe cycles", n_wr - s_wr, 3);
        chk("R1 no read strobe on write", n_rd - s_rd, 0);
        chk("R9 oe cycles on write", n_oe - s_oe, 7);

        // R3 odd write in upper half
        access(1, 16'hFF7D, 8'h77);
        chk("R3 odd write word", last_dout, 16'h773C);
        chk("R2 cs upper half", last_cs, 2'b01);
        chk("R2 reg addr upper", last_addr, 6);

        // R4 disk reads
        dsk_din = 16'hBEEF;
        snap();
        access(0, 16'hFF62, 8'h00);
        chk("R4 even read byte", cpu_rdata, 8'hEF);
        chk("R1 read strobe cycles", n_rd - s_rd, 3);
        chk("R9 no oe on read", n_oe - s_oe, 0);
        chk("R2 read reg addr", last_addr, 1);
        access(0, 16'hFF43, 8'h00);
        chk("R4 high byte from buffer", cpu_rdata, 8'hBE);
        dsk_din = 16'h1234;
        access(0, 16'hFF6F, 8'h00);
        chk("R4 odd read byte", cpu_rdata, 8'h12);
        chk("R2 odd read cs", last_cs, 2'b10);
        chk("R2 odd read addr", last_addr, 7);
        access(0, 16'hFF42, 8'h00);
        chk("R4 low byte from buffer", cpu_rdata, 8'h34);

        // R6 separate buffers
        access(1, 16'hFF42, 8'h99);
        access(0, 16'hFF42, 8'h00);
        chk("R6 read buffer not write buffer", cpu_rdata, 8'h34);

        // R5 buffer access without disk activity
        snap();
        access(0, 16'hFF43, 8'h00);
        chk("R5 buffer read data", cpu_rdata, 8'h12);
        chk("R5 no stall", n_stall - s_stall, 0);
        chk("R5 no strobe", (n_rd - s_rd) + (n_wr - s_wr), 0);

        // R8 zero counts act as one
        t_setup = 0; t_active = 0; t_recov = 0;
        snap();
        access(1, 16'hFF60, 8'h5A);
        chk("R8 stall zero counts", n_stall - s_stall, 3);
        chk("R8 strobe zero count", n_wr - s_wr, 1);
        chk("R3 even write reuse hi", last_dout, 16'hA55A);
        t_setup = 1; t_active = 4; t_recov = 2;
        snap();
        access(0, 16'hFF70, 8'h00);
        chk("R8 stall 1+4+2", n_stall - s_stall, 7);
        chk("R8 strobe 4", n_rd - s_rd, 4);
        chk("R4 read upper half", cpu_rdata, 8'h34);
        chk("R2 upper half addr 0", last_addr, 0);

        // R8 requests during stall are ignored
        t_setup = 3; t_active = 3; t_recov = 3;
        @(negedge clk);
        cpu_req = 1; cpu_wr = 1; cpu_addr = 16'hFF66; cpu_wdata = 8'hC3;
        @(negedge clk);
        cpu_addr = 16'hFF42; cpu_wdata = 8'hEE;
        repeat (2) @(negedge clk);
        cpu_req = 0;
        while (cpu_stall) @(negedge clk);
        chk("R3 write before ignored req", last_dout, 16'hA5C3);
        access(1, 16'hFF61, 8'h55);
        chk("R8 ignored req left buffer", last_dout, 16'h5599);

        // R10 unmapped accesses
        access(1, 16'hFF45, 8'hFF);
        access(1, 16'hFF41, 8'h00);
        chk("R10 reset bit untouched", dsk_reset_n, 1);
        access(0, 16'hFF44, 8'h00);
        chk("R10 unmapped read zero", cpu_rdata, 8'h00);
        access(0, 16'hFF43, 8'h00);
        chk("R10 read buffer untouched", cpu_rdata, 8'h12);
        access(1, 16'hFF60, 8'h01);
        chk("R10 write buffer untouched", last_dout, 16'hA501);

        // R7 reassert reset through bit 0 only
        access(1, 16'hFF40, 8'hFE);
        chk("R7 reset_n after write FE", dsk_reset_n, 0);
        access(0, 16'hFF40, 8'h00);
        chk("R7 readback zero", cpu_rdata, 8'h00);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule